// File: doc/BRIEF.md
# S/T Link Activation Controller

This block steps one end of a four-wire S/T subscriber link between the idle and the active condition. A mode input picks whether it behaves as the network end (NT) or as a terminal (TE). The host asks for activation or deactivation through two request inputs. A line receiver that is not part of this block reports what it sees as flags: Info1 detected, frame synchronization, the received A bit and bus activity. The block answers with the Info signal code that the transmitter must send. It also reports its current state and a single status bit.

All decisions are taken on an 8 kHz frame tick. Between ticks the state is held. The NT end has a pending-deactivation state that it leaves only after a frame-counted timeout. The status bit shows frame sync or bus activity, depending on the request inputs that were sampled at the last tick.

Top module: `stlink_act_ctrl`

## Requirements
- R1: A cycle with `rst_n`=0 at a clock edge puts the block in the deactivated state of the selected mode: `state` code 0 when `nt_mode`=1 and code 4 when `nt_mode`=0. In that state `tx_info` is 0 (Info0), and the status selection is cleared so that `status_bit` follows `bus_active`.
- R2: `state` and the status selection change only at clock edges where `frame_tick`=1. Input changes without a tick leave `state` unchanged.
- R3: An NT in Deactivated (code 0) moves to Pending-Activation (code 1) on a tick with `host_deact_req`=0 and either `host_act_req`=1 or `det_info1`=1. In code 1 it transmits Info2 (`tx_info`=2). An NT only ever transmits codes 0, 2 or 4.
- R4: An NT in code 1 moves to Activated (code 2, `tx_info`=4) on a tick with `frame_sync`=1. An NT in code 2 falls back to code 1 on a tick with `frame_sync`=0.
- R5: An NT in code 1 or code 2 moves to Pending-Deactivation (code 3, `tx_info`=0) on a tick with `host_deact_req`=1. When both requests are high, deactivation wins, so an NT in code 0 stays in code 0.
- R6: An NT in code 3 ignores every request and line flag. It returns to code 0 on exactly the TIMEOUT_TICKS-th tick after the tick on which it entered code 3. The default is 256 ticks, which is 32 ms.
- R7: A TE in Deactivated (code 4) moves to Activation-Request (code 5) on a tick with `host_act_req`=1, `host_deact_req`=0 and `frame_sync`=0. In code 5 it transmits Info1 (`tx_info`=1) while `bus_active`=0, and Info0 while `bus_active`=1.
- R8: A TE in code 4 or code 5 moves to Synchronized (code 6) on a tick with `frame_sync`=1, unless `host_deact_req`=1. In code 6 it transmits Info3 (`tx_info`=3) while `frame_sync`=1, and Info0 otherwise.
- R9: A TE in code 6 moves to Activated (code 7, `tx_info`=3) on a tick with `frame_sync`=1 and `rx_abit`=1. A TE in code 7 returns to code 6 on a tick with `frame_sync`=0 or `rx_abit`=0.
- R10: A TE in any state returns to code 4 on a tick with `host_deact_req`=1. A TE in code 6 or code 7 also returns to code 4 on a tick with `bus_active`=0. The deactivation request is checked first, then the loss of bus activity.
- R11: At each tick the status selection captures (`host_act_req`=1 and `host_deact_req`=0). While the selection is set, `status_bit` equals `frame_sync`; otherwise it equals `bus_active`.
- R12: On a tick where `nt_mode` does not match the family of the current state (codes 0–3 are NT, codes 4–7 are TE), the block enters the deactivated state of the mode now selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nt_mode | input | 1 | 1 = network end, 0 = terminal |
| frame_tick | input | 1 | One-cycle pulse per 125 µs frame |
| host_act_req | input | 1 | Host activation request |
| host_deact_req | input | 1 | Host deactivation request |
| det_info1 | input | 1 | Info1 detected on the line (NT) |
| frame_sync | input | 1 | Receiver in frame synchronization |
| rx_abit | input | 1 | Received A bit (TE) |
| bus_active | input | 1 | Signal present on the line |
| tx_info | output | 3 | Info code to transmit (0..4) |
| state | output | 3 | State code, as listed in the requirements |
| status_bit | output | 1 | Sync or bus-activity status |

## Verification
The hardest situation to reach is the end of the NT pending-deactivation window. It needs a full activation first, then a deactivation request, then exactly 256 ticks during which requests are deliberately held high without any effect. The bench walks there directly and checks the state on the 255th tick and again on the 256th. After that, a long pseudo-random run toggles the mode now and then and biases the line flags. This keeps both state families, and repeated trips through the timed window, under comparison against an arithmetic reference model.

// File: rtl/stlink_pkg.sv
package stlink_pkg;

  typedef enum logic [2:0] {
    NT_DEACT      = 3'd0,
    NT_PEND_ACT   = 3'd1,
    NT_ACTIVE     = 3'd2,
    NT_PEND_DEACT = 3'd3,
    TE_DEACT      = 3'd4,
    TE_REQUEST    = 3'd5,
    TE_SYNCED     = 3'd6,
    TE_ACTIVE     = 3'd7
  } link_state_e;

  localparam logic [2:0] INFO0 = 3'd0;
  localparam logic [2:0] INFO1 = 3'd1;
  localparam logic [2:0] INFO2 = 3'd2;
  localparam logic [2:0] INFO3 = 3'd3;
  localparam logic [2:0] INFO4 = 3'd4;

  // Line code to send for a state; TE codes depend on live line flags.
  function automatic logic [2:0] info_for(link_state_e s, logic busy, logic sync);
    case (s)
      NT_PEND_ACT: info_for = INFO2;
      NT_ACTIVE:   info_for = INFO4;
      TE_REQUEST:  info_for = busy ? INFO0 : INFO1;
      TE_SYNCED:   info_for = sync ? INFO3 : INFO0;
      TE_ACTIVE:   info_for = INFO3;
      default:     info_for = INFO0;
    endcase
  endfunction

  function automatic link_state_e idle_of(logic nt);
    idle_of = nt ? NT_DEACT : TE_DEACT;
  endfunction

endpackage

// File: rtl/stlink_frame_timer.sv
module stlink_frame_timer #(
  parameter int TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic frame_tick,
  output logic expire
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && frame_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  cnt_q <= '0;
    else if (frame_tick) cnt_q <= expire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/stlink_status_sel.sv
module stlink_status_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic act_req,
  input  logic deact_req,
  input  logic frame_sync,
  input  logic bus_active,
  output logic status_bit
);
  logic show_sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          show_sync_q <= 1'b0;
    else if (frame_tick) show_sync_q <= act_req && !deact_req;
  end

  assign status_bit = show_sync_q ? frame_sync : bus_active;
endmodule

// File: rtl/stlink_fsm.sv
module stlink_fsm
  import stlink_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nt_mode,
  input  logic        frame_tick,
  input  logic        act_req,
  input  logic        deact_req,
  input  logic        det_info1,
  input  logic        frame_sync,
  input  logic        rx_abit,
  input  logic        bus_active,
  input  logic        timer_expire,
  output link_state_e state_q
);
  link_state_e state_d;
  logic        mode_mismatch;

  assign mode_mismatch = (nt_mode == state_q[2]);

  always_comb begin
    state_d = state_q;
    if (mode_mismatch) state_d = idle_of(nt_mode);
    else begin
      case (state_q)
        NT_DEACT:      if (!deact_req && (act_req || det_info1)) state_d = NT_PEND_ACT;
        NT_PEND_ACT:   if (deact_req) state_d = NT_PEND_DEACT;
                       else if (frame_sync) state_d = NT_ACTIVE;
        NT_ACTIVE:     if (deact_req) state_d = NT_PEND_DEACT;
                       else if (!frame_sync) state_d = NT_PEND_ACT;
        NT_PEND_DEACT: if (timer_expire) state_d = NT_DEACT;
        TE_DEACT:      if (deact_req) state_d = TE_DEACT;
                       else if (frame_sync) state_d = TE_SYNCED;
                       else if (act_req) state_d = TE_REQUEST;
        TE_REQUEST:    if (deact_req) state_d = TE_DEACT;
                       else if (frame_sync) state_d = TE_SYNCED;
        TE_SYNCED:     if (deact_req || !bus_active) state_d = TE_DEACT;
                       else if (frame_sync && rx_abit) state_d = TE_ACTIVE;
        TE_ACTIVE:     if (deact_req || !bus_active) state_d = TE_DEACT;
                       else if (!frame_sync || !rx_abit) state_d = TE_SYNCED;
        default:       state_d = idle_of(nt_mode);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          state_q <= idle_of(nt_mode);
    else if (frame_tick) state_q <= state_d;
  end

  assert_dr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && deact_req && nt_mode && state_q == NT_DEACT) |=> state_q == NT_DEACT);

  assert_te_dr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && deact_req && !nt_mode && state_q[2]) |=> state_q == TE_DEACT);
endmodule

// File: rtl/stlink_act_ctrl.sv
module stlink_act_ctrl
  import stlink_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nt_mode,
  input  logic       frame_tick,
  input  logic       host_act_req,
  input  logic       host_deact_req,
  input  logic       det_info1,
  input  logic       frame_sync,
  input  logic       rx_abit,
  input  logic       bus_active,
  output logic [2:0] tx_info,
  output logic [2:0] state,
  output logic       status_bit
);
  link_state_e state_w;
  logic        timer_run;
  logic        timer_expire;

  assign timer_run = (state_w == NT_PEND_DEACT);

  stlink_frame_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run),
    .frame_tick(frame_tick), .expire(timer_expire)
  );

  stlink_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .nt_mode(nt_mode), .frame_tick(frame_tick),
    .act_req(host_act_req), .deact_req(host_deact_req), .det_info1(det_info1),
    .frame_sync(frame_sync), .rx_abit(rx_abit), .bus_active(bus_active),
    .timer_expire(timer_expire), .state_q(state_w)
  );

  stlink_status_sel u_status (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .act_req(host_act_req), .deact_req(host_deact_req),
    .frame_sync(frame_sync), .bus_active(bus_active), .status_bit(status_bit)
  );

  assign tx_info = info_for(state_w, bus_active, frame_sync);
  assign state   = state_w;

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(state));

  assert_pd_timed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_mode && state_w == NT_PEND_DEACT && !timer_expire) |=> state_w == NT_PEND_DEACT);

  assert_expire_in_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expire |-> state_w == NT_PEND_DEACT);

  assert_nt_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !state[2] |-> (tx_info == INFO0 || tx_info == INFO2 || tx_info == INFO4));

  assert_no_info1_on_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> tx_info != INFO1);
endmodule

// File: tb/stlink_act_ctrl_tb.sv
module stlink_act_ctrl_tb;
  localparam int N = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nt_mode = 1'b1, frame_tick = 1'b0, ar = 1'b0, dr = 1'b0;
  logic i1 = 1'b0, sy = 1'b0, ab = 1'b0, ba = 1'b0;
  logic [2:0] tx_info, state;
  logic status_bit;

  int checks = 0, errors = 0;
  int ms = 0, mcnt = 0;
  bit msel = 0;

  always #10 clk = ~clk;

  stlink_act_ctrl #(.TIMEOUT_TICKS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .nt_mode(nt_mode), .frame_tick(frame_tick),
    .host_act_req(ar), .host_deact_req(dr), .det_info1(i1),
    .frame_sync(sy), .rx_abit(ab), .bus_active(ba),
    .tx_info(tx_info), .state(state), .status_bit(status_bit)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tx(int s, bit busy, bit sync);
    if (s == 1) return 2;
    if (s == 2) return 4;
    if (s == 5) return busy ? 0 : 1;
    if (s == 6) return sync ? 3 : 0;
    if (s == 7) return 3;
    return 0;
  endfunction

  // Reference model of one frame decision.
  task automatic model_tick();
    int nx;
    bit nt_fam;
    nt_fam = (ms < 4);
    nx = ms;
    if (nt_fam != nt_mode) nx = nt_mode ? 0 : 4;
    else if (ms == 3) nx = (mcnt == N - 1) ? 0 : 3;
    else if (nt_fam) begin
      if (dr) nx = (ms == 0) ? 0 : 3;
      else if (ms == 0) nx = (ar || i1) ? 1 : 0;
      else nx = sy ? 2 : 1;
    end else begin
      if (dr) nx = 4;
      else if (ms >= 6 && !ba) nx = 4;
      else if (ms == 4) nx = sy ? 6 : (ar ? 5 : 4);
      else if (ms == 5) nx = sy ? 6 : 5;
      else nx = (sy && ab) ? 7 : 6;
    end
    mcnt = (ms == 3 && nx == 3) ? mcnt + 1 : 0;
    ms = nx;
    msel = ar && !dr;
  endtask

  task automatic frame();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic do_reset(bit nt);
    nt_mode = nt; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    ms = nt ? 0 : 4; mcnt = 0; msel = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state, both modes
    ba = 1'b1; sy = 1'b0;
    do_reset(1'b0);
    check("R1 te state", state, 4);
    check("R1 te tx", tx_info, 0);
    check("R1 status follows ba", status_bit, 1);
    do_reset(1'b1);
    check("R1 nt state", state, 0);
    check("R1 nt tx", tx_info, 0);

    // NT activation path
    ar = 1; frame();
    check("R3 pend act", state, 1); check("R3 info2", tx_info, 2);
    sy = 1; ar = 0; frame();
    check("R4 activated", state, 2); check("R4 info4", tx_info, 4);
    sy = 0; frame();
    check("R4 sync loss", state, 1);
    sy = 1; frame();
    check("R4 re-activated", state, 2);
    ar = 1; dr = 1; frame();
    check("R5 pend deact", state, 3); check("R5 info0", tx_info, 0);
    dr = 0; ar = 1; i1 = 1;
    for (int k = 1; k < N; k++) frame();
    check("R6 still pending at N-1", state, 3);
    frame();
    check("R6 timeout exit", state, 0);
    dr = 1; ar = 1; frame();
    check("R5 dr beats ar", state, 0);
    dr = 0; ar = 0; i1 = 1; frame();
    check("R3 info1 detect", state, 1);
    i1 = 0;

    // R12 mode switch, then TE path
    nt_mode = 0; frame();
    check("R12 to te idle", state, 4);
    ar = 1; ba = 0; sy = 0; frame();
    check("R7 request", state, 5); check("R7 info1", tx_info, 1);
    ba = 1; @(negedge clk);
    check("R7 busy info0", tx_info, 0);
    // R2: inputs change, no tick
    sy = 1; dr = 1; @(negedge clk); @(negedge clk);
    check("R2 hold no tick", state, 5);
    dr = 0; frame();
    check("R8 synced", state, 6); check("R8 info3", tx_info, 3);
    sy = 0; @(negedge clk);
    check("R8 no sync info0", tx_info, 0);
    sy = 1; ab = 1; frame();
    check("R9 activated", state, 7); check("R9 info3", tx_info, 3);
    ab = 0; frame();
    check("R9 a bit low", state, 6);
    ba = 0; frame();
    check("R10 bus idle", state, 4);
    ba = 1; sy = 0; ar = 1; frame();
    check("R10 pre request", state, 5);
    dr = 1; frame();
    check("R10 dr idle", state, 4);

    // R11 status selection latched on tick
    dr = 0; ar = 0; frame();
    sy = 1; ba = 0; ar = 1; @(negedge clk);
    check("R11 before tick", status_bit, 0);
    frame();
    check("R11 shows sync", status_bit, 1);
    dr = 1; @(negedge clk);
    check("R11 held until tick", status_bit, 1);
    frame();
    check("R11 back to ba", status_bit, 0);
    nt_mode = 1; frame();
    check("R12 to nt idle", state, 0);

    // Pseudo-random sweep against the reference model
    do_reset(1'b1);
    begin
      logic [15:0] lf = 16'hACE1;
      for (int f = 0; f < 4000; f++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (f % 700 == 699) nt_mode = ~nt_mode;
        ar = lf[0] | lf[1];
        dr = lf[2] & lf[3] & lf[4];
        i1 = lf[5];
        sy = lf[6] | lf[7];
        ab = lf[8] | lf[9];
        ba = lf[10] | lf[11] | lf[12];
        frame();
        model_tick();
        check("R3 R4 R5 R6 R7 R8 R9 R10 R12 state", state, ms);
        check("R3 R7 R8 tx", tx_info, exp_tx(ms, ba, sy));
        check("R11 status", status_bit, msel ? sy : ba);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule